// File: doc/BRIEF.md
# Level-2 Interrupt Aggregator

This block collects up to 128 level-sensitive interrupt sources, grouped into 32-bit words, and condenses them onto a small set of first-level interrupt lines plus one wake line. Every word has an enable register and a raw status register. Software reaches them, and the per-line routing masks, over a simple synchronous register bus. Status is never latched, so nothing needs acknowledging. A source stays visible in status only while its input is high.

Each first-level line `k` carries its own routing mask for every word. The line asserts when some source is active, enabled and selected by that line's mask for its word. Several lines can therefore share one set of enable and status registers while each one watches a different subset of sources. A separate wake line ORs every active, enabled source that is also selected in a wake-enable register, and it ignores the routing masks. After reset, the enables hold a forwarding value chosen by parameter, so those sources reach the outputs before any software has run.

The register bus has no stream flow control. A write takes effect at the clock edge where `bus_wr` is sampled high. A read returns its data on `bus_rdata` one cycle after `bus_rd` is sampled high, and the value stays there until the next read.

Top module: `l2_irq_aggregator`

## Requirements
- R1: After reset, `irq_o` and `wake_o` are 0. Enable word `w` holds `FWD_INIT[32w+31:32w]`, every routing mask is all ones, and every wake-enable word is 0.
- R2: Register index `i = bus_addr[7:2]`. Enable of word `w` is at `i = 2w` and status of word `w` is at `i = 2w+1`, which places them at 0x00 and 0x04 when there is a single word. Wake-enable of word `w` is at `i = 8+w`. The routing mask of line `k`, word `w`, is at `i = 16 + k*NUM_WORDS + w`. Read data appears on `bus_rdata` one cycle after `bus_rd`, and unmapped indices read as 0.
- R3: Writing 1 to an enable bit unmasks that source and writing 0 masks it. An enable register reads back the value written to it.
- R4: A status read returns the raw level of each source, whatever its enable state, after a two-flop synchroniser. A status bit clears as soon as its source clears, and nothing acknowledges it.
- R5: `irq_o[k]` is the registered OR, over all words, of status AND enable AND the routing mask of line `k`. It changes one cycle after an enable or mask write and three cycles after a source input changes.
- R6: A source whose bit is 0 in the routing mask of every line can never raise any `irq_o` bit.
- R7: `wake_o` is the registered OR of status AND enable AND wake-enable over all words, and the routing masks have no effect on it.
- R8: Writes to status indices or to unmapped indices change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | NUM_WORDS*32 | Level interrupt sources, word `w` in bits 32w+31:32w |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address, bits 7:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | NUM_OUTS | First-level interrupt lines |
| wake_o | output | 1 | Wake request |

## Verification
The bench builds the block with two words, three lines and a forwarding value that differs between the two words. This exercises the word-select decode of every register kind and the per-word reset value of the enables. One line keeps its default all-ones mask while the other two are narrowed to different words, so a single source pattern produces a different result on each line. The same configuration leaves one source uncovered by every line but enabled for wake, which separates the wake path from the routing masks.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;
  localparam int WORD_BITS     = 32;
  localparam int ADDR_BITS     = 8;
  localparam int IDX_BITS      = ADDR_BITS - 2;
  localparam int WAKE_BASE_IDX = 8;
  localparam int MAP_BASE_IDX  = 16;
  localparam int MAX_WORDS     = 4;
  localparam int MAX_MAP_REGS  = (1 << IDX_BITS) - MAP_BASE_IDX;
endpackage

// File: rtl/l2irq_sync.sv
module l2irq_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/l2irq_regs.sv
module l2irq_regs
  import l2irq_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_OUTS  = 2,
  parameter logic [NUM_WORDS*WORD_BITS-1:0] FWD_INIT = '0
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    bus_wr,
  input  logic                                    bus_rd,
  input  logic [ADDR_BITS-1:0]                    bus_addr,
  input  logic [WORD_BITS-1:0]                    bus_wdata,
  output logic [WORD_BITS-1:0]                    bus_rdata,
  input  logic [NUM_WORDS*WORD_BITS-1:0]          status_i,
  output logic [NUM_WORDS*WORD_BITS-1:0]          en_o,
  output logic [NUM_WORDS*WORD_BITS-1:0]          wake_en_o,
  output logic [NUM_OUTS*NUM_WORDS*WORD_BITS-1:0] map_o
);
  localparam int NUM_MAPS = NUM_OUTS * NUM_WORDS;

  logic [WORD_BITS-1:0] en_q   [NUM_WORDS];
  logic [WORD_BITS-1:0] wake_q [NUM_WORDS];
  logic [WORD_BITS-1:0] map_q  [NUM_MAPS];
  logic [WORD_BITS-1:0] rd_next;
  logic [IDX_BITS-1:0]  idx;

  assign idx = bus_addr[ADDR_BITS-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        en_q[w]   <= FWD_INIT[w*WORD_BITS +: WORD_BITS];
        wake_q[w] <= '0;
      end
      for (int m = 0; m < NUM_MAPS; m++) map_q[m] <= '1;
    end else if (bus_wr) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (idx == IDX_BITS'(2 * w)) en_q[w] <= bus_wdata;
        if (idx == IDX_BITS'(WAKE_BASE_IDX + w)) wake_q[w] <= bus_wdata;
      end
      for (int m = 0; m < NUM_MAPS; m++)
        if (idx == IDX_BITS'(MAP_BASE_IDX + m)) map_q[m] <= bus_wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (idx == IDX_BITS'(2 * w)) rd_next = en_q[w];
      if (idx == IDX_BITS'(2 * w + 1)) rd_next = status_i[w*WORD_BITS +: WORD_BITS];
      if (idx == IDX_BITS'(WAKE_BASE_IDX + w)) rd_next = wake_q[w];
    end
    for (int m = 0; m < NUM_MAPS; m++)
      if (idx == IDX_BITS'(MAP_BASE_IDX + m)) rd_next = map_q[m];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word_flat
    assign en_o[w*WORD_BITS +: WORD_BITS]      = en_q[w];
    assign wake_en_o[w*WORD_BITS +: WORD_BITS] = wake_q[w];
  end
  for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map_flat
    assign map_o[m*WORD_BITS +: WORD_BITS] = map_q[m];
  end
endmodule

// File: rtl/l2irq_route.sv
module l2irq_route
  import l2irq_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_OUTS  = 2
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [NUM_WORDS*WORD_BITS-1:0]          status_i,
  input  logic [NUM_WORDS*WORD_BITS-1:0]          en_i,
  input  logic [NUM_WORDS*WORD_BITS-1:0]          wake_en_i,
  input  logic [NUM_OUTS*NUM_WORDS*WORD_BITS-1:0] map_i,
  output logic [NUM_OUTS-1:0]                     irq_o,
  output logic                                    wake_o
);
  logic [NUM_WORDS*WORD_BITS-1:0] live;
  logic [NUM_OUTS-1:0]            hit;
  logic                           wake_hit;

  assign live     = status_i & en_i;
  assign wake_hit = |(live & wake_en_i);

  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_line
    logic [NUM_WORDS-1:0] word_hit;
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign word_hit[w] = |(live[w*WORD_BITS +: WORD_BITS] &
                             map_i[(k*NUM_WORDS + w)*WORD_BITS +: WORD_BITS]);
    end
    assign hit[k] = |word_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= '0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= hit;
      wake_o <= wake_hit;
    end
  end
endmodule

// File: rtl/l2_irq_aggregator.sv
module l2_irq_aggregator
  import l2irq_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_OUTS  = 2,
  parameter logic [NUM_WORDS*WORD_BITS-1:0] FWD_INIT = '0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_WORDS*WORD_BITS-1:0] src_i,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_BITS-1:0]           bus_addr,
  input  logic [WORD_BITS-1:0]           bus_wdata,
  output logic [WORD_BITS-1:0]           bus_rdata,
  output logic [NUM_OUTS-1:0]            irq_o,
  output logic                           wake_o
);
  localparam int SRC_W = NUM_WORDS * WORD_BITS;
  localparam int MAP_W = NUM_OUTS * SRC_W;

  if (NUM_WORDS < 1 || NUM_WORDS > MAX_WORDS) begin : g_bad_words
    $error("NUM_WORDS must be 1..4");
  end
  if (NUM_OUTS < 1 || NUM_OUTS * NUM_WORDS > MAX_MAP_REGS) begin : g_bad_outs
    $error("NUM_OUTS * NUM_WORDS exceeds the routing-mask space");
  end

  logic [SRC_W-1:0] status;
  logic [SRC_W-1:0] en_flat;
  logic [SRC_W-1:0] wake_flat;
  logic [MAP_W-1:0] map_flat;

  l2irq_sync #(.WIDTH(SRC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (src_i),
    .q_o (status)
  );

  l2irq_regs #(
    .NUM_WORDS (NUM_WORDS),
    .NUM_OUTS  (NUM_OUTS),
    .FWD_INIT  (FWD_INIT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .status_i  (status),
    .en_o      (en_flat),
    .wake_en_o (wake_flat),
    .map_o     (map_flat)
  );

  l2irq_route #(
    .NUM_WORDS (NUM_WORDS),
    .NUM_OUTS  (NUM_OUTS)
  ) u_route (
    .clk       (clk),
    .rst       (rst),
    .status_i  (status),
    .en_i      (en_flat),
    .wake_en_i (wake_flat),
    .map_i     (map_flat),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
  );
endmodule

// File: rtl/l2irq_chk.sv
module l2irq_chk
  import l2irq_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_OUTS  = 2
) (
  input logic                                    clk,
  input logic                                    rst,
  input logic [NUM_WORDS*WORD_BITS-1:0]          src_i,
  input logic                                    bus_rd,
  input logic [ADDR_BITS-1:0]                    bus_addr,
  input logic [WORD_BITS-1:0]                    bus_rdata,
  input logic [NUM_OUTS-1:0]                     irq_o,
  input logic                                    wake_o,
  input logic [NUM_WORDS*WORD_BITS-1:0]          en_flat,
  input logic [NUM_OUTS*NUM_WORDS*WORD_BITS-1:0] map_flat
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R4: status of word 0 reads as the source level seen three samples back
  a_r4_status_raw: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) && $past(bus_rd && bus_addr == 8'h04)
      |-> bus_rdata == $past(src_i[WORD_BITS-1:0], 3));

  // R5 / R7: quiet sources keep every line and the wake line low
  a_r5_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) && ($past(src_i, 3) == '0) |-> (irq_o == '0) && !wake_o);

  // R3: with every enable cleared, no line asserts on the next cycle
  a_r3_all_masked: assert property (@(posedge clk) disable iff (rst)
    (en_flat == '0) |=> (irq_o == '0) && !wake_o);

  // R6: a line whose routing masks are all zero stays low
  a_r6_empty_route: assert property (@(posedge clk) disable iff (rst)
    (map_flat[NUM_WORDS*WORD_BITS-1:0] == '0) |=> !irq_o[0]);
endmodule

bind l2_irq_aggregator l2irq_chk #(
  .NUM_WORDS (NUM_WORDS),
  .NUM_OUTS  (NUM_OUTS)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .src_i     (src_i),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .wake_o    (wake_o),
  .en_flat   (en_flat),
  .map_flat  (map_flat)
);

// File: tb/l2_irq_aggregator_tb_top.sv
module l2_irq_aggregator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 2;
  localparam int NO = 3;
  localparam logic [63:0] FWD = 64'h0000_0100_8000_0001;
  localparam int NVEC = 8;
  // {source word 1, source word 0, expected irq_o, expected wake_o}
  localparam logic [67:0] VEC [NVEC] = '{
    {32'h0000_0000, 32'h0000_0000, 3'b000, 1'b0},
    {32'h0000_0000, 32'h0000_0001, 3'b101, 1'b0},
    {32'h0000_0000, 32'h0000_0100, 3'b100, 1'b0},
    {32'h0000_0000, 32'h0001_0000, 3'b000, 1'b0},
    {32'h0000_0001, 32'h0000_0000, 3'b110, 1'b1},
    {32'h0000_0100, 32'h0000_0000, 3'b000, 1'b0},
    {32'h0000_0002, 32'h0000_0080, 3'b111, 1'b0},
    {32'hFFFF_FF00, 32'hFFFF_0000, 3'b000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NO-1:0] irq_o;
  logic        wake_o;
  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  l2_irq_aggregator #(.NUM_WORDS(NW), .NUM_OUTS(NO), .FWD_INIT(FWD)) dut_i (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", 32'(irq_o), 32'h0);
    check("R1 wake", 32'(wake_o), 32'h0);
    rd(8'h00, rv); check("R1 enable word0", rv, 32'h8000_0001);
    rd(8'h08, rv); check("R1 enable word1", rv, 32'h0000_0100);
    rd(8'h54, rv); check("R1 map line2 word1", rv, 32'hFFFF_FFFF);
    rd(8'h20, rv); check("R1 wake-enable word0", rv, 32'h0);
    rd(8'h0C, rv); check("R2 status word1", rv, 32'h0);

    // configuration for the vector table (R2, R3)
    wr(8'h00, 32'h0000_FFFF);
    wr(8'h08, 32'h0000_00FF);
    wr(8'h40, 32'h0000_00FF);
    wr(8'h44, 32'h0000_0000);
    wr(8'h48, 32'h0000_0000);
    wr(8'h24, 32'h0000_0001);
    rd(8'h08, rv); check("R3 enable readback", rv, 32'h0000_00FF);
    rd(8'h40, rv); check("R2 map line0 word0", rv, 32'h0000_00FF);

    // R5 / R7 vector walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      src_i = VEC[i][67:4];
      settle();
      check($sformatf("R5 vector %0d irq", i), 32'(irq_o), 32'(VEC[i][3:1]));
      check($sformatf("R7 vector %0d wake", i), 32'(wake_o), 32'(VEC[i][0]));
    end

    // R6: source word1 bit3 enabled but covered by no line
    wr(8'h4C, 32'hFFFF_FFF7);
    wr(8'h54, 32'hFFFF_FFF7);
    @(negedge clk);
    src_i = 64'h0000_0008_0000_0000;
    settle();
    check("R6 uncovered source", 32'(irq_o), 32'h0);
    check("R7 wake not selected", 32'(wake_o), 32'h0);
    wr(8'h24, 32'h0000_0009);
    check("R7 wake ignores maps", 32'(wake_o), 32'h0);
    @(negedge clk);
    check("R7 wake after enable", 32'(wake_o), 32'h1);
    check("R6 lines stay low", 32'(irq_o), 32'h0);

    // R5: one-cycle latency after an enable write
    @(negedge clk);
    src_i = 64'h0000_0000_0000_0001;
    settle();
    check("R5 before mask", 32'(irq_o), 32'b101);
    wr(8'h00, 32'h0000_0000);
    check("R5 mask write not yet seen", 32'(irq_o), 32'b101);
    @(negedge clk);
    check("R3 masked source", 32'(irq_o), 32'b000);
    wr(8'h00, 32'h0000_0001);
    @(negedge clk);
    check("R3 unmasked source", 32'(irq_o), 32'b101);

    // R5: three-cycle latency from a source edge
    @(negedge clk);
    src_i = '0;
    settle();
    @(negedge clk);
    src_i = 64'h0000_0000_0000_0001;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R5 source after two edges", 32'(irq_o), 32'b000);
    @(negedge clk);
    check("R5 source after three edges", 32'(irq_o), 32'b101);

    // R4: raw status, no latch; R8 status write ignored
    @(negedge clk);
    src_i = 64'h0000_0000_0001_0000;
    settle();
    rd(8'h04, rv); check("R4 raw status disabled bit", rv, 32'h0001_0000);
    check("R4 disabled bit no irq", 32'(irq_o), 32'b000);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, rv); check("R8 status write ignored", rv, 32'h0001_0000);
    @(negedge clk);
    src_i = '0;
    settle();
    rd(8'h04, rv); check("R4 status clears with source", rv, 32'h0);

    // R8 / R2: unmapped index
    wr(8'h3C, 32'h1234_5678);
    rd(8'h3C, rv); check("R2 unmapped reads zero", rv, 32'h0);
    rd(8'h00, rv); check("R8 enable untouched", rv, 32'h0000_0001);
    rd(8'h24, rv); check("R2 wake-enable word1", rv, 32'h0000_0009);
    rd(8'h54, rv); check("R2 map line2 word1", rv, 32'hFFFF_FFF7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule